// File: doc/BRIEF.md
# Write-Driven Interrupt Register Unit

This block is a slave on the IO side of a cache controller. Devices signal interrupts with ordinary 32-bit IO writes, not with dedicated wires. Each IO address is a 32-bit word address. It is split into a device type, a device number and a word offset, using one of three layouts. A configuration input selects the layout: one with a few types and a wide offset, one of middle width, and one with many devices and a narrow offset.

The unit answers writes directed at its own type and number. It also takes broadcast writes aimed at its type, whatever the number in the address. It keeps two 32-bit registers:

- a pending-interrupt register, which is set by a set-bits write, cleared by a clear-bits write, and readable;
- an enable register, which is written and read directly.

A single request line to the processor is high whenever a pending bit is also enabled. Choosing among the pending bits is left to software.

Top module: `intr_io_unit`

## Requirements
- R1: After reset the pending register and the enable register read zero, `irq_out` is low and `rsp_valid` is low.
- R2: Layout select 0 (wide-offset): the type is `io_addr[31:28]`, which must be 1..14, and it is compared with `cfg_type[3:0]`. The number is `io_addr[27:24]`, compared with `cfg_num[3:0]`. The word offset is `io_addr[23:0]`.
- R3: Layout select 1 (middle): `io_addr[31:29]` must be zero. The type is `io_addr[28:24]`, which must be nonzero. The number is `io_addr[23:16]`, compared with `cfg_num[7:0]`. The offset is `io_addr[15:0]`.
- R4: Layout select 2 (narrow): `io_addr[31:25]` must be zero. The type is `io_addr[24:20]`, which must be nonzero. The number is `io_addr[19:10]`, compared with all of `cfg_num`. The offset is `io_addr[9:0]`.
- R5: The unit ignores a request whose type or number does not match, or whose address does not fit the selected layout. The registers keep their values.
- R6: A write with `io_bcast` high matches when the type matches, whatever the number field holds.
- R7: A write to offset 1 ORs the data into the pending register. Zero data bits leave their pending bits unchanged.
- R8: A write to offset 2 clears every pending bit whose data bit is one. The other pending bits are unchanged.
- R9: Offset 3 is the enable register, which is read and written whole. Offset 0 reads the pending register. A write to offset 0 changes nothing.
- R10: `irq_out` is high exactly when (pending AND enable) is nonzero. It follows a register write in the cycle after that write is accepted.
- R11: A matching read without broadcast gives `rsp_valid` high for one cycle, in the cycle after the request. `rsp_rdata` carries the register value from before any write in that same cycle. Writes, broadcast reads and non-matching reads give no response.
- R12: A read of any offset other than 0 or 3 returns zero. A write to any offset other than 1, 2 or 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_layout | input | 2 | Address layout select: 0 wide-offset, 1 middle, 2 narrow, 3 none |
| cfg_type | input | 5 | Own device type |
| cfg_num | input | 10 | Own device number |
| io_valid | input | 1 | Request present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_bcast | input | 1 | Broadcast-by-type request |
| io_addr | input | 32 | IO word address |
| io_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong pending or enable bit shows at `irq_out` in the cycle after the write that caused it. It also shows at the next read of offset 0 or 3, which returns the value one cycle later. A decode error shows in two ways. A wrongly accepted write changes a register, and a read-back then exposes it. A wrongly refused read shows as a missing response, or as a response where none was due. The scoreboard catches both in the cycle after the request.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int TYPE_W = 5;
    localparam int NUM_W  = 10;
    localparam int OFS_W  = 24;

    typedef enum logic [1:0] {
        LAYOUT_WIDE   = 2'd0,
        LAYOUT_MIDDLE = 2'd1,
        LAYOUT_NARROW = 2'd2
    } layout_e;

    localparam logic [OFS_W-1:0] OFS_PEND  = 24'd0;
    localparam logic [OFS_W-1:0] OFS_SET   = 24'd1;
    localparam logic [OFS_W-1:0] OFS_CLR   = 24'd2;
    localparam logic [OFS_W-1:0] OFS_ENBL  = 24'd3;
endpackage

// File: rtl/intr_addr_decode.sv
module intr_addr_decode
    import intr_pkg::*;
(
    input  logic [1:0]        layout,
    input  logic [TYPE_W-1:0] own_type,
    input  logic [NUM_W-1:0]  own_num,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bcast,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs
);
    logic form_ok;
    logic type_ok;
    logic num_ok;

    always_comb begin
        form_ok = 1'b0;
        type_ok = 1'b0;
        num_ok  = 1'b0;
        ofs     = '0;
        case (layout)
            LAYOUT_WIDE: begin
                form_ok = (addr[31:28] != 4'h0) && (addr[31:28] != 4'hF);
                type_ok = (addr[31:28] == own_type[3:0]);
                num_ok  = (addr[27:24] == own_num[3:0]);
                ofs     = addr[23:0];
            end
            LAYOUT_MIDDLE: begin
                form_ok = (addr[31:29] == 3'b000) && (addr[28:24] != 5'd0);
                type_ok = (addr[28:24] == own_type);
                num_ok  = (addr[23:16] == own_num[7:0]);
                ofs     = {8'd0, addr[15:0]};
            end
            LAYOUT_NARROW: begin
                form_ok = (addr[31:25] == 7'd0) && (addr[24:20] != 5'd0);
                type_ok = (addr[24:20] == own_type);
                num_ok  = (addr[19:10] == own_num);
                ofs     = {14'd0, addr[9:0]};
            end
            default: begin
                form_ok = 1'b0;
            end
        endcase
        hit = form_ok && type_ok && (bcast || num_ok);
    end
endmodule

// File: rtl/intr_regs.sv
module intr_regs
    import intr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic         wr_enbl,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend,
    output logic [W-1:0] enbl
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] enbl;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;

    always_comb begin
        set_vec = wr_set ? wdata : '0;
        clr_vec = wr_clr ? wdata : '0;
        st_d      = st_q;
        st_d.pend = set_vec | (st_q.pend & ~clr_vec);
        if (wr_enbl) st_d.enbl = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign enbl = st_q.enbl;

    AST_SET_BITS_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pend & $past(wdata)) == $past(wdata)));                      // R7
    AST_CLR_BITS_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set) |=> ((pend & $past(wdata)) == '0));                  // R8
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> $stable(pend));                                  // R9
    AST_ENBL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enbl |=> $stable(enbl));                                              // R9
endmodule

// File: rtl/intr_io_unit.sv
module intr_io_unit
    import intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_layout,
    input  logic [4:0]        cfg_type,
    input  logic [9:0]        cfg_num,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic              io_bcast,
    input  logic [31:0]       io_addr,
    input  logic [31:0]       io_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              irq_out
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rsp_t;

    logic              hit;
    logic [OFS_W-1:0]  ofs;
    logic              wr_hit, rd_hit;
    logic              wr_set, wr_clr, wr_enbl;
    logic [DATA_W-1:0] pend, enbl;
    rsp_t              rsp_d, rsp_q;

    intr_addr_decode i_dec (
        .layout   (cfg_layout),
        .own_type (cfg_type),
        .own_num  (cfg_num),
        .addr     (io_addr),
        .bcast    (io_bcast),
        .hit      (hit),
        .ofs      (ofs)
    );

    assign wr_hit  = io_valid && io_write && hit;
    assign rd_hit  = io_valid && !io_write && !io_bcast && hit;
    assign wr_set  = wr_hit && (ofs == OFS_SET);
    assign wr_clr  = wr_hit && (ofs == OFS_CLR);
    assign wr_enbl = wr_hit && (ofs == OFS_ENBL);

    intr_regs #(.W(DATA_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_set  (wr_set),
        .wr_clr  (wr_clr),
        .wr_enbl (wr_enbl),
        .wdata   (io_wdata),
        .pend    (pend),
        .enbl    (enbl)
    );

    always_comb begin
        rsp_d.vld  = rd_hit;
        rsp_d.data = '0;
        if (rd_hit) begin
            if (ofs == OFS_PEND)      rsp_d.data = pend;
            else if (ofs == OFS_ENBL) rsp_d.data = enbl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_rdata = rsp_q.data;
    assign irq_out   = |(pend & enbl);

    AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(io_valid && !io_write && !io_bcast));                  // R11
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_write) |=> !rsp_valid);                                   // R11
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(wr_set || wr_enbl));                             // R10
    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(wr_clr || wr_enbl));                             // R10
    AST_NARROW_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && cfg_layout == 2'd2) |-> (io_addr[31:25] == 7'd0));             // R4
endmodule

// File: tb/test_intr_io_unit.sv
`timescale 1ns/100ps
module test_intr_io_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_layout = 2'd0;
    logic [4:0]  cfg_type = 5'd6;
    logic [9:0]  cfg_num = 10'h2A5;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic        io_bcast = 1'b0;
    logic [31:0] io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] m_pend = '0;
    logic [31:0] m_enbl = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    intr_io_unit i_intr_io_unit (
        .clk(clk), .rst_n(rst_n), .cfg_layout(cfg_layout), .cfg_type(cfg_type),
        .cfg_num(cfg_num), .io_valid(io_valid), .io_write(io_write),
        .io_bcast(io_bcast), .io_addr(io_addr), .io_wdata(io_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] a_wide(input int t, input int n, input int o);
        return {t[3:0], n[3:0], o[23:0]};
    endfunction
    function automatic logic [31:0] a_mid(input int t, input int n, input int o);
        return {3'b000, t[4:0], n[7:0], o[15:0]};
    endfunction
    function automatic logic [31:0] a_nar(input int t, input int n, input int o);
        return {7'd0, t[4:0], n[9:0], o[9:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input string tag, input logic [31:0] a, input logic [31:0] d,
                         input bit bc, input bit hits, input int o);
        @(negedge clk);
        io_valid = 1'b1; io_write = 1'b1; io_bcast = bc; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_valid = 1'b0; io_write = 1'b0; io_bcast = 1'b0;
        if (hits) begin
            if (o == 1) m_pend = m_pend | d;
            else if (o == 2) m_pend = m_pend & ~d;
            else if (o == 3) m_enbl = d;
        end
        chk({tag, " R10 irq"}, {31'd0, irq_out}, {31'd0, |(m_pend & m_enbl)});
    endtask

    task automatic do_rd(input string tag, input logic [31:0] a, input bit bc,
                         input bit hits, input int o);
        @(negedge clk);
        io_valid = 1'b1; io_write = 1'b0; io_bcast = bc; io_addr = a;
        if (hits && !bc) begin
            exp_q.push_back(o == 0 ? m_pend : (o == 3 ? m_enbl : 32'd0));
            tag_q.push_back(tag);
        end
        @(negedge clk);
        io_valid = 1'b0; io_bcast = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, rsp_rdata, e);
            end
        end
    end

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
        chk("R1 rsp after reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        // wide layout: type 6, number 5
        do_rd("R1 pending reset", a_wide(6, 5, 0), 0, 1, 0);
        do_rd("R1 enable reset", a_wide(6, 5, 3), 0, 1, 3);
        do_wr("R9 enable write", a_wide(6, 5, 3), 32'hFFFF_0000, 0, 1, 3);
        do_rd("R9 enable read", a_wide(6, 5, 3), 0, 1, 3);
        do_wr("R2 R7 set", a_wide(6, 5, 1), 32'h0001_0001, 0, 1, 1);
        do_rd("R2 R7 pending", a_wide(6, 5, 0), 0, 1, 0);
        do_wr("R7 set zero bits", a_wide(6, 5, 1), 32'h0000_0000, 0, 1, 1);
        do_wr("R5 wrong number", a_wide(6, 4, 1), 32'h0000_0002, 0, 0, 1);
        do_wr("R5 wrong type", a_wide(7, 5, 1), 32'h0000_0002, 0, 0, 1);
        do_rd("R5 pending kept", a_wide(6, 5, 0), 0, 1, 0);
        do_wr("R6 broadcast set", a_wide(6, 9, 1), 32'h0000_0004, 1, 1, 1);
        do_rd("R6 pending", a_wide(6, 5, 0), 0, 1, 0);
        do_rd("R11 broadcast read", a_wide(6, 5, 0), 1, 0, 0);
        do_rd("R5 wrong number read", a_wide(6, 3, 0), 0, 0, 0);
        do_wr("R8 clear", a_wide(6, 5, 2), 32'h0001_0000, 0, 1, 2);
        do_rd("R8 pending", a_wide(6, 5, 0), 0, 1, 0);
        do_wr("R9 write offset 0", a_wide(6, 5, 0), 32'hFFFF_FFFF, 0, 1, 0);
        do_rd("R9 pending unchanged", a_wide(6, 5, 0), 0, 1, 0);
        do_rd("R12 read offset 7", a_wide(6, 5, 7), 0, 1, 7);
        do_rd("R12 read set offset", a_wide(6, 5, 1), 0, 1, 1);
        do_wr("R12 write offset 7", a_wide(6, 5, 7), 32'h00F0_0000, 0, 1, 7);
        do_wr("R12 write high offset", a_wide(6, 5, 24'h10_0001), 32'h00F0_0000, 0, 1, 99);
        do_rd("R12 pending unchanged", a_wide(6, 5, 0), 0, 1, 0);
        // middle layout: type 6, number 0xA5
        @(negedge clk); cfg_layout = 2'd1;
        do_wr("R5 wide form in middle", a_wide(6, 5, 1), 32'h0000_0100, 0, 0, 1);
        do_wr("R3 set", a_mid(6, 'hA5, 1), 32'h8000_0000, 0, 1, 1);
        do_rd("R3 pending", a_mid(6, 'hA5, 0), 0, 1, 0);
        do_wr("R10 enable off", a_mid(6, 'hA5, 3), 32'h0000_0000, 0, 1, 3);
        // narrow layout: type 6, number 0x2A5
        @(negedge clk); cfg_layout = 2'd2;
        do_wr("R5 middle form in narrow", a_mid(6, 'hA5, 1), 32'h0000_0200, 0, 0, 1);
        do_wr("R4 set", a_nar(6, 'h2A5, 1), 32'h0000_0100, 0, 1, 1);
        do_rd("R4 pending", a_nar(6, 'h2A5, 0), 0, 1, 0);
        do_wr("R5 narrow wrong number", a_nar(6, 'h0A5, 2), 32'hFFFF_FFFF, 0, 0, 2);
        do_wr("R10 enable on", a_nar(6, 'h2A5, 3), 32'h0000_0100, 0, 1, 3);
        do_wr("R6 R8 broadcast clear", a_nar(6, 'h001, 2), 32'h0000_0100, 1, 1, 2);
        do_rd("R8 pending narrow", a_nar(6, 'h2A5, 0), 0, 1, 0);
        do_rd("R9 enable narrow", a_nar(6, 'h2A5, 3), 0, 1, 3);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        report();
    end
endmodule